// File: doc/BRIEF.md
# Overlapped Window Pipeline Scheduler

This block sequences one decoding run of a turbo-like iterative decoder whose frame is cut into windows, each window's soft data sitting in its own single-port memory bank. Every iteration passes each window through four processing steps in a fixed order: outer soft-in/soft-out pass, inward parity-check pass, inner soft-in/soft-out pass, outward parity-check pass. The scheduler issues a start strobe with a window index to each step's engine, waits for that engine's done pulse, and lets the four steps work on different windows at the same time.

The inward parity-check step trails the outer step by a programmable gap: it may begin a window only once the outer step has finished enough windows ahead of it. The inner and outward steps each follow their predecessor window by window. The outer step of the next iteration may reuse a window only after the outward step has released it. A hardware comparator watches the window indices of all busy steps and latches a conflict flag if two of them ever address the same bank in one cycle. Window count, gap and iteration count are sampled when a run is launched.

Top module: `window_pipe_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `ph_start`, `ph_active`, `busy`, `finished` and `conflict` are all 0.
- R2: A `go` pulse is accepted only when `busy` is 0, `cfg_windows` is in 1..MAX_WIN and `cfg_iters` is nonzero; a rejected `go` starts nothing, and a `go` during a run does not alter the window count or iteration count in use.
- R3: Step p (0 outer, 1 inward check, 2 inner, 3 outward check) emits exactly one `ph_start[p]` strobe per window, with field `ph_win[p*WIN_W +: WIN_W]` giving window indices 0,1,..,W-1 in that order once per iteration, W*I strobes in all; a step issues no new strobe until its `ph_done[p]` has closed the current window.
- R4: The inward check step begins window w of an iteration only after the outer step has completed min(w+Δ, W) windows of that same iteration; a Δ larger than W is treated as W.
- R5: The inner step begins a window only after the inward check step has completed that window, and the outward check step only after the inner step has completed it.
- R6: The outer step begins window w of iteration i>0 only after the outward check step has completed window w of iteration i-1.
- R7: `conflict` rises when two steps are active on the same window index in one cycle and stays high until the next accepted `go`; with Δ ≥ 1 it never rises, with Δ = 0 the inward step starts alongside the outer step on window 0 and it rises.
- R8: When the outward check step completes the final window of the final iteration, `finished` is high for exactly one cycle and `busy` is 0 in that same cycle.
- R9: With W ≥ 2 at least two steps are active in the same cycle during a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Launch pulse, samples the configuration |
| cfg_windows | input | CNT_W | Windows per iteration (1..MAX_WIN) |
| cfg_delta | input | CNT_W | Gap Δ between outer and inward check steps |
| cfg_iters | input | IT_W | Number of iterations (nonzero) |
| ph_done | input | 4 | Per-step completion pulse for the current window |
| ph_start | output | 4 | Per-step window start strobe |
| ph_active | output | 4 | Per-step window in progress |
| ph_win | output | 4*WIN_W | Per-step window index, field p at bits p*WIN_W |
| busy | output | 1 | Run in progress |
| finished | output | 1 | One-cycle end-of-run pulse |
| conflict | output | 1 | Sticky bank conflict flag |

## Verification
The assertions assume each engine raises `ph_done[p]` for one cycle per window, only while `ph_active[p]` is high and never in the cycle of its own start strobe. The bench's engine models respect this: each arms a timer on its strobe and pulses done once after a latency of at least one cycle, with different latencies per step so that every dependency becomes the binding one in some run. The bench recomputes the gap, follow-on and reuse rules from its own counts of strobes and done pulses, taking as visible to the scheduler only those done pulses it has already sampled.

// File: rtl/wps_pkg.sv
package wps_pkg;

    // default sizing
    localparam int WPS_MAX_WIN_DEF = 8;
    localparam int WPS_IT_W_DEF    = 5;

    // processing steps, in pipeline order
    localparam int NPH = 4;

    typedef enum logic [1:0] {
        PH_OUTER   = 2'd0,
        PH_CHK_IN  = 2'd1,
        PH_INNER   = 2'd2,
        PH_CHK_OUT = 2'd3
    } phase_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RUN  = 1'b1
    } run_e;

    function automatic int unsigned idx_of(phase_e ph);
        return int'(ph);
    endfunction

endpackage

// File: rtl/wps_phase_unit.sv
module wps_phase_unit #(
    parameter int CNT_W = 4,
    parameter int WIN_W = 3,
    parameter int LIN_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             fire,
    input  logic             done,
    input  logic [CNT_W-1:0] cfg_win,
    output logic             active,
    output logic             strobe,
    output logic [WIN_W-1:0] win,
    output logic [LIN_W-1:0] cnt
);

    logic last_win;

    always_comb begin
        last_win = (CNT_W'(win) == (cfg_win - CNT_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active <= 1'b0;
            strobe <= 1'b0;
            win    <= '0;
            cnt    <= '0;
        end else begin
            strobe <= fire;
            if (fire) begin
                active <= 1'b1;
            end else if (active && done) begin
                active <= 1'b0;
                cnt    <= cnt + LIN_W'(1);
                if (last_win) begin
                    win <= '0;
                end else begin
                    win <= win + WIN_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/wps_start_gate.sv
module wps_start_gate import wps_pkg::*; #(
    parameter int CNT_W = 4,
    parameter int WIN_W = 3,
    parameter int LIN_W = 9
) (
    input  logic             run,
    input  logic [LIN_W-1:0] total,
    input  logic [CNT_W-1:0] cfg_win,
    input  logic [CNT_W-1:0] cfg_dlt,
    input  logic [NPH-1:0]   active,
    input  logic [LIN_W-1:0] cnt [NPH],
    input  logic [WIN_W-1:0] win_in,
    output logic [NPH-1:0]   fire
);

    localparam int SW = CNT_W + 1;
    localparam int EW = LIN_W + 1;

    logic [SW-1:0]    ahead;
    logic [SW-1:0]    need_w;
    logic [LIN_W-1:0] need;
    logic [NPH-1:0]   dep;
    logic [NPH-1:0]   room;

    always_comb begin
        // windows the outer step must have closed before the inward check may open win_in
        ahead  = SW'(win_in) + SW'(cfg_dlt);
        need_w = (ahead > SW'(cfg_win)) ? SW'(cfg_win) : ahead;
        need   = cnt[idx_of(PH_CHK_IN)] - LIN_W'(win_in) + LIN_W'(need_w);

        dep[idx_of(PH_OUTER)]   = (EW'(cnt[idx_of(PH_CHK_OUT)]) + EW'(cfg_win))
                                  > EW'(cnt[idx_of(PH_OUTER)]);
        dep[idx_of(PH_CHK_IN)]  = cnt[idx_of(PH_OUTER)] >= need;
        dep[idx_of(PH_INNER)]   = cnt[idx_of(PH_CHK_IN)] > cnt[idx_of(PH_INNER)];
        dep[idx_of(PH_CHK_OUT)] = cnt[idx_of(PH_INNER)] > cnt[idx_of(PH_CHK_OUT)];

        for (int p = 0; p < NPH; p++) begin
            room[p] = run && !active[p] && (cnt[p] < total);
        end
        fire = dep & room;
    end

endmodule

// File: rtl/wps_bank_guard.sv
module wps_bank_guard import wps_pkg::*; #(
    parameter int WIN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [NPH-1:0]   active,
    input  logic [WIN_W-1:0] win [NPH],
    output logic             flag
);

    logic [NPH*NPH-1:0] hit;

    genvar gi, gj;
    generate
        for (gi = 0; gi < NPH; gi++) begin : g_row
            for (gj = 0; gj < NPH; gj++) begin : g_col
                if (gj > gi) begin : g_pair
                    assign hit[gi*NPH+gj] = active[gi] && active[gj] && (win[gi] == win[gj]);
                end else begin : g_none
                    assign hit[gi*NPH+gj] = 1'b0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag <= 1'b0;
        end else if (|hit) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/window_pipe_sched.sv
module window_pipe_sched import wps_pkg::*; #(
    parameter int MAX_WIN = WPS_MAX_WIN_DEF,
    parameter int IT_W    = WPS_IT_W_DEF,
    localparam int WIN_W  = $clog2(MAX_WIN),
    localparam int CNT_W  = $clog2(MAX_WIN + 1),
    localparam int LIN_W  = CNT_W + IT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [CNT_W-1:0]     cfg_windows,
    input  logic [CNT_W-1:0]     cfg_delta,
    input  logic [IT_W-1:0]      cfg_iters,
    input  logic [NPH-1:0]       ph_done,
    output logic [NPH-1:0]       ph_start,
    output logic [NPH-1:0]       ph_active,
    output logic [NPH*WIN_W-1:0] ph_win,
    output logic                 busy,
    output logic                 finished,
    output logic                 conflict
);

    run_e             run_q;
    logic [CNT_W-1:0] win_q;
    logic [CNT_W-1:0] dlt_q;
    logic [LIN_W-1:0] total_q;
    logic             finish_q;
    logic             go_ok;
    logic             last_done;

    logic [NPH-1:0]   fire;
    logic [LIN_W-1:0] cnt_a [NPH];
    logic [WIN_W-1:0] win_a [NPH];

    always_comb begin
        go_ok = go && (run_q == RS_IDLE) && (cfg_windows != '0)
                && (int'(cfg_windows) <= MAX_WIN) && (cfg_iters != '0);
        last_done = ph_active[idx_of(PH_CHK_OUT)] && ph_done[idx_of(PH_CHK_OUT)]
                    && (cnt_a[idx_of(PH_CHK_OUT)] == total_q - LIN_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= RS_IDLE;
            win_q    <= '0;
            dlt_q    <= '0;
            total_q  <= '0;
            finish_q <= 1'b0;
        end else begin
            finish_q <= 1'b0;
            if (go_ok) begin
                run_q   <= RS_RUN;
                win_q   <= cfg_windows;
                dlt_q   <= cfg_delta;
                total_q <= LIN_W'(cfg_windows) * LIN_W'(cfg_iters);
            end else if (run_q == RS_RUN && last_done) begin
                run_q    <= RS_IDLE;
                finish_q <= 1'b1;
            end
        end
    end

    wps_start_gate #(
        .CNT_W(CNT_W),
        .WIN_W(WIN_W),
        .LIN_W(LIN_W)
    ) u_gate (
        .run    (run_q == RS_RUN),
        .total  (total_q),
        .cfg_win(win_q),
        .cfg_dlt(dlt_q),
        .active (ph_active),
        .cnt    (cnt_a),
        .win_in (win_a[idx_of(PH_CHK_IN)]),
        .fire   (fire)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NPH; gp++) begin : g_ph
            wps_phase_unit #(
                .CNT_W(CNT_W),
                .WIN_W(WIN_W),
                .LIN_W(LIN_W)
            ) u_unit (
                .clk    (clk),
                .rst    (rst),
                .clr    (go_ok),
                .fire   (fire[gp]),
                .done   (ph_done[gp]),
                .cfg_win(win_q),
                .active (ph_active[gp]),
                .strobe (ph_start[gp]),
                .win    (win_a[gp]),
                .cnt    (cnt_a[gp])
            );
            assign ph_win[gp*WIN_W +: WIN_W] = win_a[gp];
        end
    endgenerate

    wps_bank_guard #(
        .WIN_W(WIN_W)
    ) u_guard (
        .clk   (clk),
        .rst   (rst),
        .clr   (go_ok),
        .active(ph_active),
        .win   (win_a),
        .flag  (conflict)
    );

    assign busy     = (run_q == RS_RUN);
    assign finished = finish_q;

endmodule

// File: rtl/window_pipe_sched_chk.sv
module window_pipe_sched_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic [3:0]       ph_start,
    input logic [3:0]       ph_active,
    input logic             busy,
    input logic             finished,
    input logic             conflict,
    input logic [CNT_W-1:0] dlt_q
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (ph_start == 4'd0 && ph_active == 4'd0 && !busy && !finished && !conflict))
        else $error("reset state not quiet");

    p_idle_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ph_start == 4'd0))
        else $error("start strobe outside a run");

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        (ph_start != 4'd0) |=> ((ph_start & $past(ph_start)) == 4'd0))
        else $error("strobe held for two cycles");

    p_strobe_active_r3: assert property (@(posedge clk) disable iff (rst)
        (ph_start & ~ph_active) == 4'd0)
        else $error("strobe without active window");

    p_conflict_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (conflict && !go) |=> conflict)
        else $error("conflict flag dropped");

    p_conflict_gap_r7: assert property (@(posedge clk) disable iff (rst)
        conflict |-> (dlt_q == '0))
        else $error("conflict with nonzero gap");

    p_finish_single_r8: assert property (@(posedge clk) disable iff (rst)
        finished |=> !finished)
        else $error("finished longer than one cycle");

    p_finish_idle_r8: assert property (@(posedge clk) disable iff (rst)
        finished |-> !busy)
        else $error("busy at finish");

endmodule

bind window_pipe_sched window_pipe_sched_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .ph_start (ph_start),
    .ph_active(ph_active),
    .busy     (busy),
    .finished (finished),
    .conflict (conflict),
    .dlt_q    (dlt_q)
);

// File: tb/sim_window_pipe_sched.sv
module sim_window_pipe_sched;

    localparam int MAX_WIN = 8;
    localparam int IT_W    = 5;
    localparam int WIN_W   = 3;
    localparam int CNT_W   = 4;
    localparam int NV      = 9;

    // windows, gap, iterations, latency of steps 0..3, expected conflict
    localparam int VEC [NV][8] = '{
        '{4, 2, 2,  3, 1, 2, 1, 0},
        '{8, 1, 3,  1, 1, 1, 1, 0},
        '{5, 5, 1,  2, 2, 2, 2, 0},
        '{3, 7, 2,  1, 3, 1, 2, 0},
        '{6, 0, 1,  4, 1, 1, 1, 1},
        '{1, 1, 4,  1, 2, 1, 1, 0},
        '{8, 3, 2,  2, 1, 3, 1, 0},
        '{2, 1, 12, 1, 1, 1, 1, 0},
        '{7, 2, 3,  1, 4, 1, 3, 0}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 go = 1'b0;
    logic [CNT_W-1:0]     cfg_windows = '0;
    logic [CNT_W-1:0]     cfg_delta = '0;
    logic [IT_W-1:0]      cfg_iters = '0;
    logic [3:0]           ph_done = 4'd0;
    logic [3:0]           ph_start;
    logic [3:0]           ph_active;
    logic [4*WIN_W-1:0]   ph_win;
    logic                 busy;
    logic                 finished;
    logic                 conflict;

    window_pipe_sched #(.MAX_WIN(MAX_WIN), .IT_W(IT_W)) u0 (
        .clk(clk), .rst(rst), .go(go),
        .cfg_windows(cfg_windows), .cfg_delta(cfg_delta), .cfg_iters(cfg_iters),
        .ph_done(ph_done), .ph_start(ph_start), .ph_active(ph_active),
        .ph_win(ph_win), .busy(busy), .finished(finished), .conflict(conflict)
    );

    always #5 clk = ~clk;

    int n_total = 0;
    int n_bad = 0;

    // engine model and rule monitor state
    int  nstart [4];
    int  cd [4];
    int  cp [4];
    int  tmr [4];
    int  lat [4];
    int  rule_bad [4];
    int  order_bad;
    int  nfin;
    int  maxc;
    int  mW = 1;
    int  mD = 1;
    bit  clr_req = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        for (int p = 0; p < 4; p++) begin
            nstart[p] = 0; cd[p] = 0; cp[p] = 0; tmr[p] = 0; lat[p] = 1; rule_bad[p] = 0;
        end
        order_bad = 0; nfin = 0; maxc = 0;
        forever begin
            @(negedge clk);
            if (clr_req) begin
                for (int p = 0; p < 4; p++) begin
                    nstart[p] = 0; cd[p] = 0; cp[p] = 0; tmr[p] = 0; rule_bad[p] = 0;
                end
                order_bad = 0; nfin = 0; maxc = 0;
                clr_req = 1'b0;
            end
            if (finished) nfin++;
            if ($countones(ph_active) > maxc) maxc = $countones(ph_active);
            for (int p = 0; p < 4; p++) begin
                if (ph_start[p]) begin
                    int k, w, lim;
                    k = nstart[p];
                    w = k % mW;
                    if (int'(ph_win[p*WIN_W +: WIN_W]) != w) order_bad++;
                    case (p)
                        0: if (cp[3] + mW < k + 1) rule_bad[0]++;
                        1: begin
                            lim = (w + mD > mW) ? mW : w + mD;
                            if (cp[0] < k - w + lim) rule_bad[1]++;
                        end
                        2: if (cp[1] < k + 1) rule_bad[2]++;
                        default: if (cp[2] < k + 1) rule_bad[3]++;
                    endcase
                    nstart[p]++;
                end
            end
            for (int p = 0; p < 4; p++) cp[p] = cd[p];
            for (int p = 0; p < 4; p++) begin
                ph_done[p] = 1'b0;
                if (ph_start[p]) begin
                    tmr[p] = lat[p];
                end else if (tmr[p] > 0) begin
                    tmr[p]--;
                    if (tmr[p] == 0) begin
                        ph_done[p] = 1'b1;
                        cd[p]++;
                    end
                end
            end
        end
    end

    task automatic run_case(input int v, input bit midgo);
        int w, d, it, cyc;
        w = VEC[v][0]; d = VEC[v][1]; it = VEC[v][2];
        @(posedge clk); #2;
        mW = w; mD = d;
        for (int p = 0; p < 4; p++) lat[p] = VEC[v][3+p];
        cfg_windows = CNT_W'(w); cfg_delta = CNT_W'(d); cfg_iters = IT_W'(it);
        clr_req = 1'b1;
        @(posedge clk); #2; go = 1'b1;
        @(posedge clk); #2; go = 1'b0;
        if (midgo) begin
            repeat (6) @(posedge clk);
            #2; cfg_windows = CNT_W'(2); cfg_iters = IT_W'(1); go = 1'b1;
            @(posedge clk); #2; go = 1'b0;
        end
        cyc = 0;
        while (nfin == 0 && cyc < 20000) begin
            @(posedge clk); cyc++;
        end
        check(cyc < 20000, "R8", "run completes before timeout", cyc, 0);
        repeat (3) @(posedge clk);
        #2;
        for (int p = 0; p < 4; p++)
            check(nstart[p] == w * it, "R3", $sformatf("case %0d step %0d strobe count", v, p),
                  nstart[p], w * it);
        check(order_bad == 0, "R3", $sformatf("case %0d window order", v), order_bad, 0);
        check(rule_bad[1] == 0, "R4", $sformatf("case %0d inward gap", v), rule_bad[1], 0);
        check(rule_bad[2] + rule_bad[3] == 0, "R5", $sformatf("case %0d follow-on", v),
              rule_bad[2] + rule_bad[3], 0);
        check(rule_bad[0] == 0, "R6", $sformatf("case %0d window reuse", v), rule_bad[0], 0);
        check(int'(conflict) == VEC[v][7], "R7", $sformatf("case %0d conflict", v),
              int'(conflict), VEC[v][7]);
        check(nfin == 1 && !busy, "R8", $sformatf("case %0d finish pulses", v), nfin, 1);
        if (w >= 2)
            check(maxc >= 2, "R9", $sformatf("case %0d overlap", v), maxc, 2);
    endtask

    task automatic try_bad_go(input int w, input int it, input string what);
        @(posedge clk); #2;
        cfg_windows = CNT_W'(w); cfg_iters = IT_W'(it); cfg_delta = CNT_W'(1);
        clr_req = 1'b1;
        @(posedge clk); #2; go = 1'b1;
        @(posedge clk); #2; go = 1'b0;
        repeat (6) @(posedge clk);
        #2;
        check(!busy && nstart[0] == 0, "R2", what, int'(busy) + nstart[0], 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_total++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, during and just after reset
        repeat (3) @(posedge clk);
        #2;
        check(ph_start == 4'd0 && ph_active == 4'd0, "R1", "step outputs in reset",
              int'(ph_start | ph_active), 0);
        check(!busy && !finished && !conflict, "R1", "status in reset",
              int'({busy, finished, conflict}), 0);
        rst = 1'b0;
        @(posedge clk); #2;
        check(ph_active == 4'd0 && !busy && !conflict, "R1", "after reset release",
              int'(ph_active), 0);

        // R2: rejected launches
        try_bad_go(0, 2, "zero windows ignored");
        try_bad_go(9, 2, "too many windows ignored");
        try_bad_go(4, 0, "zero iterations ignored");

        // table walk
        for (int v = 0; v < NV; v++) run_case(v, 1'b0);

        // R2: launch during a run leaves the run unchanged
        run_case(0, 1'b1);

        // R7: flag cleared by next accepted launch after a conflicting run
        run_case(4, 1'b0);
        @(posedge clk); #2;
        check(conflict, "R7", "flag held after run", int'(conflict), 1);
        run_case(1, 1'b0);

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule